// File: doc/BRIEF.md
# Windowed Pixel Write Engine

This block receives a stream of 16-bit pixel words through one data port and scatters them into a rectangular window of a word-addressed frame buffer. The window is described by start and end coordinates, a bytes-per-pixel value and a source selector. A transfer is armed in one of two ways: explicitly, by a pulse that marks a write to the source selector, or implicitly, by the first data word that arrives while no transfer is pending. When a transfer is armed, the block checks the window settings and latches the window geometry: its width, its height, its word count, its origin address and the number of words per row. It then issues one frame-buffer write for each accepted word, in raster order.

When the last word of a window has been written, the block pulses a completion flag. In the same cycle it widens a dirty bounding box so that the box also covers the window just written. The display refresh logic reads that box and later empties it with a clear pulse. The box then holds no area: its minimum corner sits at the display size and its maximum corner at zero. Frame-buffer memory and colour conversion sit outside this block.

Top module: `pixwin_engine`

## Requirements
- R1: After reset, `busy`, `mem_we` and `win_done` are 0, and the dirty box is empty: `dirty_x0` = `disp_w`, `dirty_y0` = `disp_h`, and `dirty_x1` = `dirty_y1` = 0.
- R2: Arming fails in any of these cases: `cfg_src` > 3, `cfg_bpp` = 0, `cfg_x1` < `cfg_x0`, `cfg_y1` < `cfg_y0`, or a computed word count of 0. A data word that arrives with nothing pending and a failed arm is dropped: there is no write and `busy` stays 0.
- R3: Width = x1 − x0 + 1 and height = y1 − y0 + 1. The transfer length in words is floor(bpp × width × height / 2), and exactly that many writes occur before completion.
- R4: Each accepted word gives exactly one `mem_we` pulse, one cycle after its `wr_valid`, with `mem_wdata` equal to that word. `mem_we` is never raised without a preceding strobe.
- R5: The first write goes to origin = y0 × `cfg_pitch` + floor(x0 × bpp / 2). A row holds ceil(bpp × width / 2) words. Addresses increment by 1 within a row. After the last word of a row, the row base advances by `cfg_pitch`.
- R6: The final word's write cycle also carries a one-cycle `win_done` pulse, and `busy` is 0 from that cycle on.
- R7: In the cycle of `win_done`, the dirty box becomes the union of its previous extent with the window, where the window's end coordinates are exclusive: [x0, x1+1) × [y0, y1+1).
- R8: `dirty_clr` empties the box on the next cycle. If a window completes in that same cycle, the box equals exactly that window.
- R9: A `src_sel_wr` pulse with valid settings re-arms the block at once, even while it is busy, and discards the remaining words of the old transfer. With invalid settings, the pending transfer continues unchanged.
- R10: If `src_sel_wr` and `wr_valid` are high in the same cycle, the word becomes the first word of the newly armed transfer.
- R11: A data word that arrives while idle, with valid settings, arms the transfer and is itself written to the origin address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_x0 | input | COORD_W | Window start column |
| cfg_y0 | input | COORD_W | Window start row |
| cfg_x1 | input | COORD_W | Window end column (inclusive) |
| cfg_y1 | input | COORD_W | Window end row (inclusive) |
| cfg_bpp | input | BPP_W | Bytes per pixel |
| cfg_src | input | SRC_W | Source selector, valid values 0..3 |
| cfg_pitch | input | PITCH_W | Frame-buffer line pitch in words |
| disp_w | input | COORD_W+1 | Display width in pixels |
| disp_h | input | COORD_W+1 | Display height in lines |
| src_sel_wr | input | 1 | Pulse: source selector written, arm now |
| wr_valid | input | 1 | Data word strobe |
| wr_data | input | DATA_W | Data word |
| mem_we | output | 1 | Frame-buffer write enable |
| mem_addr | output | ADDR_W | Frame-buffer word address |
| mem_wdata | output | DATA_W | Frame-buffer write data |
| busy | output | 1 | Words remain in the armed transfer |
| win_done | output | 1 | Pulse: last word of a window written |
| dirty_clr | input | 1 | Pulse from refresh: empty the dirty box |
| dirty_x0 | output | COORD_W+1 | Dirty box minimum column |
| dirty_x1 | output | COORD_W+1 | Dirty box column end (exclusive) |
| dirty_y0 | output | COORD_W+1 | Dirty box minimum row |
| dirty_y1 | output | COORD_W+1 | Dirty box row end (exclusive) |

## Verification
The windows cover each pixel size from one to four bytes. With two bytes per pixel, one word is one pixel. With three bytes per pixel, rows hold a whole number of words. With one byte per pixel and an odd width, the row word count rounds up while the total word count rounds down, which separates the per-row count from the total count. Windows that fail each rejection rule separate dropped words from writes. Re-arming in mid-transfer with valid settings, then with invalid settings, and arming in the same cycle as a word, separate the two arming paths. Clear pulses, both on their own and coinciding with a completion, separate emptying the box from growing it, and random windows with random strobe gaps exercise the union of the box over many windows.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;
    localparam int PW_COORD_W = 10;
    localparam int PW_BPP_W   = 3;
    localparam int PW_SRC_W   = 3;
    localparam int PW_PITCH_W = 12;
    localparam int PW_ADDR_W  = 20;
    localparam int PW_DATA_W  = 16;
    localparam int PW_MAX_SRC = 3;
endpackage

// File: rtl/pixwin_setup.sv
module pixwin_setup #(
    parameter int COORD_W = pixwin_pkg::PW_COORD_W,
    parameter int BPP_W   = pixwin_pkg::PW_BPP_W,
    parameter int SRC_W   = pixwin_pkg::PW_SRC_W,
    parameter int PITCH_W = pixwin_pkg::PW_PITCH_W,
    parameter int ADDR_W  = pixwin_pkg::PW_ADDR_W,
    parameter int MAX_SRC = pixwin_pkg::PW_MAX_SRC,
    localparam int DIM_W  = COORD_W + 1,
    localparam int RW_W   = DIM_W + BPP_W,
    localparam int FULL_W = BPP_W + 2 * DIM_W,
    localparam int LEN_W  = FULL_W - 1
) (
    input  logic [COORD_W-1:0] x0,
    input  logic [COORD_W-1:0] y0,
    input  logic [COORD_W-1:0] x1,
    input  logic [COORD_W-1:0] y1,
    input  logic [BPP_W-1:0]   bpp,
    input  logic [SRC_W-1:0]   src,
    input  logic [PITCH_W-1:0] pitch,
    output logic               ok,
    output logic [DIM_W-1:0]   wid,
    output logic [DIM_W-1:0]   hgt,
    output logic [LEN_W-1:0]   len,
    output logic [RW_W-1:0]    row_words,
    output logic [ADDR_W-1:0]  origin
);
    localparam int OW = COORD_W + PITCH_W + 1;
    localparam int XB = COORD_W + BPP_W;

    logic              geom_ok;
    logic [FULL_W-1:0] full;
    logic [RW_W:0]     rw_full;
    logic [XB-1:0]     x_bytes;
    logic [OW-1:0]     org_full;

    always_comb begin
        geom_ok  = (src <= SRC_W'(MAX_SRC)) && (bpp != '0) && (x1 >= x0) && (y1 >= y0);
        wid      = DIM_W'(x1) - DIM_W'(x0) + DIM_W'(1);
        hgt      = DIM_W'(y1) - DIM_W'(y0) + DIM_W'(1);
        full     = FULL_W'(bpp) * FULL_W'(wid) * FULL_W'(hgt);
        len      = LEN_W'(full >> 1);
        rw_full  = (RW_W+1)'(bpp) * (RW_W+1)'(wid) + (RW_W+1)'(1);
        row_words = RW_W'(rw_full >> 1);
        x_bytes  = XB'(x0) * XB'(bpp);
        org_full = OW'(y0) * OW'(pitch) + OW'(x_bytes >> 1);
        origin   = ADDR_W'(org_full);
        ok       = geom_ok && (len != '0);
    end
endmodule

// File: rtl/pixwin_walker.sv
module pixwin_walker #(
    parameter int COORD_W = pixwin_pkg::PW_COORD_W,
    parameter int BPP_W   = pixwin_pkg::PW_BPP_W,
    parameter int PITCH_W = pixwin_pkg::PW_PITCH_W,
    parameter int ADDR_W  = pixwin_pkg::PW_ADDR_W,
    parameter int DATA_W  = pixwin_pkg::PW_DATA_W,
    localparam int DIM_W  = COORD_W + 1,
    localparam int RW_W   = DIM_W + BPP_W,
    localparam int LEN_W  = BPP_W + 2 * DIM_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_sel_wr,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               cfg_ok,
    input  logic [COORD_W-1:0] cfg_x0,
    input  logic [COORD_W-1:0] cfg_y0,
    input  logic [DIM_W-1:0]   cfg_wid,
    input  logic [DIM_W-1:0]   cfg_hgt,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [RW_W-1:0]    cfg_rwords,
    input  logic [ADDR_W-1:0]  cfg_origin,
    input  logic [PITCH_W-1:0] cfg_pitch,
    output logic               busy,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               win_done,
    output logic               commit,
    output logic [COORD_W-1:0] box_x0,
    output logic [COORD_W-1:0] box_y0,
    output logic [DIM_W-1:0]   box_x1,
    output logic [DIM_W-1:0]   box_y1
);
    typedef struct packed {
        logic               busy;
        logic [LEN_W-1:0]   rem;
        logic [RW_W-1:0]    col;
        logic [RW_W-1:0]    rwords;
        logic [ADDR_W-1:0]  row_base;
        logic [PITCH_W-1:0] pitch;
        logic [COORD_W-1:0] bx0;
        logic [COORD_W-1:0] by0;
        logic [DIM_W-1:0]   bx1;
        logic [DIM_W-1:0]   by1;
        logic               we;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic               done;
    } walk_t;

    walk_t st_d, st_q;
    logic  arm_d;
    logic  last_d;

    always_comb begin
        st_d    = st_q;
        st_d.we   = 1'b0;
        st_d.done = 1'b0;
        last_d  = 1'b0;
        arm_d   = cfg_ok && (src_sel_wr || (wr_valid && !st_q.busy));
        if (arm_d) begin
            st_d.busy     = 1'b1;
            st_d.rem      = cfg_len;
            st_d.col      = '0;
            st_d.rwords   = cfg_rwords;
            st_d.row_base = cfg_origin;
            st_d.pitch    = cfg_pitch;
            st_d.bx0      = cfg_x0;
            st_d.by0      = cfg_y0;
            st_d.bx1      = DIM_W'(cfg_x0) + cfg_wid;
            st_d.by1      = DIM_W'(cfg_y0) + cfg_hgt;
        end
        if (wr_valid && st_d.busy) begin
            last_d     = (st_d.rem == LEN_W'(1));
            st_d.we    = 1'b1;
            st_d.addr  = st_d.row_base + ADDR_W'(st_d.col);
            st_d.data  = wr_data;
            st_d.rem   = st_d.rem - LEN_W'(1);
            if (RW_W'(st_d.col + RW_W'(1)) == st_d.rwords) begin
                st_d.col      = '0;
                st_d.row_base = st_d.row_base + ADDR_W'(st_d.pitch);
            end else begin
                st_d.col = st_d.col + RW_W'(1);
            end
            if (last_d) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.data;
    assign win_done  = st_q.done;
    assign commit    = st_d.done;
    assign box_x0    = st_d.bx0;
    assign box_y0    = st_d.by0;
    assign box_x1    = st_d.bx1;
    assign box_y1    = st_d.by1;

    AST_WE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(wr_valid)); // R4

    AST_DROP_WHEN_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(st_q.busy) && $past(wr_valid) && !$past(cfg_ok)) |-> !mem_we); // R2

    AST_BUSY_RISE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(src_sel_wr || wr_valid)); // R11

    AST_REM_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy) && $past(wr_valid) && !$past(src_sel_wr))
        |-> (st_q.rem == $past(st_q.rem) - LEN_W'(1))); // R3

    AST_HOLD_WITHOUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_valid) && !$past(src_sel_wr)) |-> $stable(st_q.rem)); // R9
endmodule

// File: rtl/pixwin_dirty.sv
module pixwin_dirty #(
    parameter int COORD_W = pixwin_pkg::PW_COORD_W,
    localparam int DIM_W  = COORD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIM_W-1:0]   disp_w,
    input  logic [DIM_W-1:0]   disp_h,
    input  logic               clr,
    input  logic               commit,
    input  logic [COORD_W-1:0] bx0,
    input  logic [COORD_W-1:0] by0,
    input  logic [DIM_W-1:0]   bx1,
    input  logic [DIM_W-1:0]   by1,
    output logic [DIM_W-1:0]   minx,
    output logic [DIM_W-1:0]   maxx,
    output logic [DIM_W-1:0]   miny,
    output logic [DIM_W-1:0]   maxy
);
    typedef struct packed {
        logic [DIM_W-1:0] minx;
        logic [DIM_W-1:0] maxx;
        logic [DIM_W-1:0] miny;
        logic [DIM_W-1:0] maxy;
    } box_t;

    box_t box_d, box_q, empty_box;

    always_comb begin
        empty_box = '{minx: disp_w, maxx: '0, miny: disp_h, maxy: '0};
        box_d     = clr ? empty_box : box_q;
        if (commit) begin
            if (DIM_W'(bx0) < box_d.minx) box_d.minx = DIM_W'(bx0);
            if (bx1 > box_d.maxx)         box_d.maxx = bx1;
            if (DIM_W'(by0) < box_d.miny) box_d.miny = DIM_W'(by0);
            if (by1 > box_d.maxy)         box_d.maxy = by1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            box_q <= empty_box;
        end else begin
            box_q <= box_d;
        end
    end

    assign minx = box_q.minx;
    assign maxx = box_q.maxx;
    assign miny = box_q.miny;
    assign maxy = box_q.maxy;

    AST_EMPTY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && !$past(commit)) |->
        (maxx == '0 && maxy == '0 && minx == $past(disp_w) && miny == $past(disp_h))); // R8

    AST_BOX_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (minx <= $past(minx) && maxx >= $past(maxx)
                         && miny <= $past(miny) && maxy >= $past(maxy))); // R7

    AST_COMMIT_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(commit) |-> (minx <= DIM_W'($past(bx0)) && maxx >= $past(bx1)
                           && miny <= DIM_W'($past(by0)) && maxy >= $past(by1))); // R7
endmodule

// File: rtl/pixwin_engine.sv
module pixwin_engine #(
    parameter int COORD_W = pixwin_pkg::PW_COORD_W,
    parameter int BPP_W   = pixwin_pkg::PW_BPP_W,
    parameter int SRC_W   = pixwin_pkg::PW_SRC_W,
    parameter int PITCH_W = pixwin_pkg::PW_PITCH_W,
    parameter int ADDR_W  = pixwin_pkg::PW_ADDR_W,
    parameter int DATA_W  = pixwin_pkg::PW_DATA_W,
    parameter int MAX_SRC = pixwin_pkg::PW_MAX_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] cfg_x0,
    input  logic [COORD_W-1:0] cfg_y0,
    input  logic [COORD_W-1:0] cfg_x1,
    input  logic [COORD_W-1:0] cfg_y1,
    input  logic [BPP_W-1:0]   cfg_bpp,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic [COORD_W:0]   disp_w,
    input  logic [COORD_W:0]   disp_h,
    input  logic               src_sel_wr,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               busy,
    output logic               win_done,
    input  logic               dirty_clr,
    output logic [COORD_W:0]   dirty_x0,
    output logic [COORD_W:0]   dirty_x1,
    output logic [COORD_W:0]   dirty_y0,
    output logic [COORD_W:0]   dirty_y1
);
    localparam int DIM_W = COORD_W + 1;
    localparam int RW_W  = DIM_W + BPP_W;
    localparam int LEN_W = BPP_W + 2 * DIM_W - 1;

    logic               set_ok;
    logic [DIM_W-1:0]   set_wid, set_hgt;
    logic [LEN_W-1:0]   set_len;
    logic [RW_W-1:0]    set_rwords;
    logic [ADDR_W-1:0]  set_origin;
    logic               commit;
    logic [COORD_W-1:0] box_x0, box_y0;
    logic [DIM_W-1:0]   box_x1, box_y1;

    pixwin_setup #(
        .COORD_W(COORD_W), .BPP_W(BPP_W), .SRC_W(SRC_W),
        .PITCH_W(PITCH_W), .ADDR_W(ADDR_W), .MAX_SRC(MAX_SRC)
    ) u_setup (
        .x0(cfg_x0), .y0(cfg_y0), .x1(cfg_x1), .y1(cfg_y1),
        .bpp(cfg_bpp), .src(cfg_src), .pitch(cfg_pitch),
        .ok(set_ok), .wid(set_wid), .hgt(set_hgt), .len(set_len),
        .row_words(set_rwords), .origin(set_origin)
    );

    pixwin_walker #(
        .COORD_W(COORD_W), .BPP_W(BPP_W), .PITCH_W(PITCH_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_walker (
        .clk(clk), .rst_n(rst_n),
        .src_sel_wr(src_sel_wr), .wr_valid(wr_valid), .wr_data(wr_data),
        .cfg_ok(set_ok), .cfg_x0(cfg_x0), .cfg_y0(cfg_y0),
        .cfg_wid(set_wid), .cfg_hgt(set_hgt), .cfg_len(set_len),
        .cfg_rwords(set_rwords), .cfg_origin(set_origin), .cfg_pitch(cfg_pitch),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .win_done(win_done), .commit(commit),
        .box_x0(box_x0), .box_y0(box_y0), .box_x1(box_x1), .box_y1(box_y1)
    );

    pixwin_dirty #(
        .COORD_W(COORD_W)
    ) u_dirty (
        .clk(clk), .rst_n(rst_n), .disp_w(disp_w), .disp_h(disp_h),
        .clr(dirty_clr), .commit(commit),
        .bx0(box_x0), .by0(box_y0), .bx1(box_x1), .by1(box_y1),
        .minx(dirty_x0), .maxx(dirty_x1), .miny(dirty_y0), .maxy(dirty_y1)
    );
endmodule

// File: tb/pixwin_engine_tb.sv
module pixwin_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cfg_x0 = '0, cfg_y0 = '0, cfg_x1 = '0, cfg_y1 = '0;
    logic [2:0]  cfg_bpp = 3'd2, cfg_src = '0;
    logic [11:0] cfg_pitch = 12'd64;
    logic [10:0] disp_w = 11'd64, disp_h = 11'd48;
    logic        src_sel_wr = 1'b0, wr_valid = 1'b0, dirty_clr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        mem_we, busy, win_done;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [10:0] dirty_x0, dirty_x1, dirty_y0, dirty_y1;

    int checks = 0, fails = 0, we_cnt = 0, done_cnt = 0, cycles = 0;
    bit finished = 1'b0;

    // reference model state
    int m_busy, m_rem, m_col, m_rw, m_rb, m_pitch, m_bx0, m_by0, m_bx1, m_by1;
    int e_we, e_addr, e_data, e_done;
    int d_minx, d_maxx, d_miny, d_maxy;
    int t_w, t_h, t_len, t_ok, t_commit;

    always #2 clk = ~clk;

    pixwin_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_x0(cfg_x0), .cfg_y0(cfg_y0), .cfg_x1(cfg_x1), .cfg_y1(cfg_y1),
        .cfg_bpp(cfg_bpp), .cfg_src(cfg_src), .cfg_pitch(cfg_pitch),
        .disp_w(disp_w), .disp_h(disp_h),
        .src_sel_wr(src_sel_wr), .wr_valid(wr_valid), .wr_data(wr_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .win_done(win_done), .dirty_clr(dirty_clr),
        .dirty_x0(dirty_x0), .dirty_x1(dirty_x1), .dirty_y0(dirty_y0), .dirty_y1(dirty_y1)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rem = 0; m_col = 0;
            e_we = 0; e_done = 0; e_addr = 0; e_data = 0;
            d_minx = int'(disp_w); d_maxx = 0; d_miny = int'(disp_h); d_maxy = 0;
        end else begin
            e_we = 0; e_done = 0; t_commit = 0;
            t_w = int'(cfg_x1) - int'(cfg_x0) + 1;
            t_h = int'(cfg_y1) - int'(cfg_y0) + 1;
            t_ok = (cfg_src <= 3 && cfg_bpp != 0 && t_w > 0 && t_h > 0) ? 1 : 0;
            t_len = (t_ok != 0) ? (int'(cfg_bpp) * t_w * t_h) / 2 : 0;
            if (t_len == 0) t_ok = 0;
            if (t_ok != 0 && (src_sel_wr || (wr_valid && m_busy == 0))) begin
                m_busy = 1; m_rem = t_len; m_col = 0;
                m_rw = (int'(cfg_bpp) * t_w + 1) / 2;
                m_rb = int'(cfg_y0) * int'(cfg_pitch) + (int'(cfg_x0) * int'(cfg_bpp)) / 2;
                m_pitch = int'(cfg_pitch);
                m_bx0 = int'(cfg_x0); m_by0 = int'(cfg_y0);
                m_bx1 = int'(cfg_x1) + 1; m_by1 = int'(cfg_y1) + 1;
            end
            if (wr_valid && m_busy != 0) begin
                e_we = 1; e_addr = (m_rb + m_col) % (1 << 20); e_data = int'(wr_data);
                m_rem--; m_col++;
                if (m_col == m_rw) begin m_col = 0; m_rb += m_pitch; end
                if (m_rem == 0) begin m_busy = 0; e_done = 1; t_commit = 1; end
            end
            if (dirty_clr) begin
                d_minx = int'(disp_w); d_maxx = 0; d_miny = int'(disp_h); d_maxy = 0;
            end
            if (t_commit != 0) begin
                if (m_bx0 < d_minx) d_minx = m_bx0;
                if (m_bx1 > d_maxx) d_maxx = m_bx1;
                if (m_by0 < d_miny) d_miny = m_by0;
                if (m_by1 > d_maxy) d_maxy = m_by1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R4 mem_we", int'(mem_we), e_we);
            if (e_we != 0) begin
                check("R5 mem_addr", int'(mem_addr), e_addr);
                check("R4 mem_wdata", int'(mem_wdata), e_data);
            end
            check("R6 win_done", int'(win_done), e_done);
            check("R2 busy", int'(busy), m_busy);
            check("R7 dirty_x0", int'(dirty_x0), d_minx);
            check("R7 dirty_x1", int'(dirty_x1), d_maxx);
            check("R7 dirty_y0", int'(dirty_y0), d_miny);
            check("R7 dirty_y1", int'(dirty_y1), d_maxy);
            if (mem_we) we_cnt++;
            if (win_done) done_cnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(input bit v, input logic [15:0] d, input bit s, input bit c);
        @(negedge clk);
        wr_valid = v; wr_data = d; src_sel_wr = s; dirty_clr = c;
    endtask

    task automatic setwin(input int x0, input int y0, input int x1, input int y1,
                          input int bpp, input int src);
        @(negedge clk);
        wr_valid = 1'b0; src_sel_wr = 1'b0; dirty_clr = 1'b0;
        cfg_x0 = 10'(x0); cfg_y0 = 10'(y0); cfg_x1 = 10'(x1); cfg_y1 = 10'(y1);
        cfg_bpp = 3'(bpp); cfg_src = 3'(src);
    endtask

    task automatic settle();
        step(1'b0, 16'h0, 1'b0, 1'b0);
        #1;
    endtask

    task automatic send(input int n, input int base);
        for (int i = 0; i < n; i++) step(1'b1, 16'(base + i), 1'b0, 1'b0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 busy", int'(busy), 0);
        check("R1 mem_we", int'(mem_we), 0);
        check("R1 dirty_x0", int'(dirty_x0), 64);
        check("R1 dirty_y0", int'(dirty_y0), 48);
        check("R1 dirty_x1", int'(dirty_x1) + int'(dirty_y1), 0);

        // R11 / R3: first word arms, bpp 2, 3x2 window -> 6 words, origin 66
        setwin(2, 1, 4, 2, 2, 0);
        we_cnt = 0; done_cnt = 0;
        step(1'b1, 16'hA000, 1'b0, 1'b0);
        settle();
        check("R11 first addr", int'(mem_addr), 66);
        check("R11 busy", int'(busy), 1);
        send(5, 16'hA001);
        settle();
        check("R3 word count bpp2", we_cnt, 6);
        check("R6 done count", done_cnt, 1);
        check("R7 box x", int'(dirty_x0) * 100 + int'(dirty_x1), 205);
        check("R7 box y", int'(dirty_y0) * 100 + int'(dirty_y1), 103);

        // R5 / R3: bpp 3, 4x2 -> 12 words, 6 per row
        setwin(0, 0, 3, 1, 3, 1);
        we_cnt = 0;
        send(12, 16'hB000);
        settle();
        check("R3 word count bpp3", we_cnt, 12);

        // R5: bpp 1, odd width 3 -> 1 word total
        setwin(5, 3, 7, 3, 1, 2);
        we_cnt = 0;
        send(1, 16'hC000);
        settle();
        check("R3 word count bpp1", we_cnt, 1);
        check("R5 addr bpp1", int'(mem_addr), 3 * 64 + 2);

        // R2: rejected settings drop words
        setwin(0, 0, 1, 1, 2, 4);
        we_cnt = 0;
        send(2, 16'hD000);
        settle();
        check("R2 src>3 dropped", we_cnt * 10 + int'(busy), 0);
        setwin(0, 0, 1, 1, 0, 0);
        send(2, 16'hD100);
        settle();
        check("R2 bpp0 dropped", we_cnt * 10 + int'(busy), 0);
        setwin(4, 0, 3, 1, 2, 0);
        send(1, 16'hD200);
        settle();
        check("R2 x1<x0 dropped", we_cnt * 10 + int'(busy), 0);
        setwin(0, 2, 1, 1, 2, 0);
        send(1, 16'hD300);
        settle();
        check("R2 y1<y0 dropped", we_cnt * 10 + int'(busy), 0);
        setwin(9, 9, 9, 9, 1, 0);
        send(1, 16'hD400);
        settle();
        check("R2 zero length dropped", we_cnt * 10 + int'(busy), 0);

        // R8: clear alone empties the box
        step(1'b0, 16'h0, 1'b0, 1'b1);
        settle();
        check("R8 cleared x0", int'(dirty_x0), 64);
        check("R8 cleared x1", int'(dirty_x1), 0);

        // R9: re-arm while busy discards old words
        setwin(0, 0, 2, 1, 2, 0);
        we_cnt = 0; done_cnt = 0;
        step(1'b0, 16'h0, 1'b1, 1'b0);
        send(2, 16'hE000);
        setwin(10, 5, 11, 5, 2, 1);
        step(1'b0, 16'h0, 1'b1, 1'b0);
        send(2, 16'hE100);
        settle();
        check("R9 rearm words", we_cnt, 4);
        check("R9 rearm done", done_cnt, 1);
        check("R9 box only new window", int'(dirty_x0) * 100 + int'(dirty_x1), 1012);

        // R9: invalid re-arm keeps pending transfer
        setwin(0, 0, 3, 0, 2, 0);
        we_cnt = 0;
        step(1'b0, 16'h0, 1'b1, 1'b0);
        send(1, 16'hE200);
        setwin(0, 0, 3, 0, 2, 5);
        step(1'b0, 16'h0, 1'b1, 1'b0);
        settle();
        check("R9 still busy", int'(busy), 1);
        send(3, 16'hE300);
        settle();
        check("R9 old transfer completes", we_cnt * 10 + int'(busy), 40);

        // R10: arm and word in the same cycle
        setwin(1, 2, 2, 2, 2, 3);
        step(1'b1, 16'hF000, 1'b1, 1'b0);
        settle();
        check("R10 first addr", int'(mem_addr), 2 * 64 + 1);
        check("R10 first data", int'(mem_wdata), 16'hF000);

        // R8: clear coincident with the last word
        step(1'b1, 16'hF001, 1'b0, 1'b1);
        settle();
        check("R8 box x after clear+commit", int'(dirty_x0) * 100 + int'(dirty_x1), 103);
        check("R8 box y after clear+commit", int'(dirty_y0) * 100 + int'(dirty_y1), 203);

        // random windows with gaps and occasional clears
        for (int k = 0; k < 40; k++) begin
            int x0r, y0r, wr, hr, br, len, sent;
            x0r = $urandom_range(0, 30); y0r = $urandom_range(0, 20);
            wr = $urandom_range(1, 9); hr = $urandom_range(1, 4);
            br = $urandom_range(1, 4);
            setwin(x0r, y0r, x0r + wr - 1, y0r + hr - 1, br, $urandom_range(0, 3));
            len = (br * wr * hr) / 2;
            sent = 0;
            while (sent < len) begin
                bit v;
                v = ($urandom_range(0, 3) != 0);
                step(v, 16'($urandom), 1'b0, ($urandom_range(0, 15) == 0));
                if (v) sent++;
            end
        end
        settle();
        settle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule